// File: doc/BRIEF.md
# SPI Link Presence Handshake

This block sits on the master side of a serial link whose slave may be powered or plugged separately. It never assumes the far end is there. Through a single-byte exchange port it keeps sending filler bytes. The slave's data line is pulled up, so an all-ones reply means nobody is attached. When a different reply appears, the block sends a reserved link token and waits for the slave to echo it. Only after that echo does it raise link-up.

Once the link is up, the block keeps sending filler until the slave answers with filler or with the first byte of a packet. At that point the link counts as settled and the exchange port is left quiet. After each packet, the surrounding logic can pulse a re-check request. The block then sends the token again and expects the echo. If the re-check fails, or the slave goes silent while the link is settling, the block emits a one-cycle link-lost pulse, drops link-up and goes back to polling.

Each exchange is a request held high together with a transmit byte. The shifter completes it with a one-cycle done strobe that carries the received byte. A new request may follow in the cycle right after done.

Top module: `spi_link_guard`

## Requirements
- R1: During reset and in the first cycle after it, `xfer_req`, `link_up`, `link_lost`, `settled` and `hdr_strobe` are all 0.
- R2: While every reply is 0xFF, the block issues filler exchanges (`xfer_tx` = NULL_BYTE, default 0x00). Between the end of one exchange and the next request, `xfer_req` stays low for exactly POLL_GAP clock cycles, and the same holds after reset.
- R3: A polling reply other than 0xFF makes the next exchange carry LINK_TOKEN (default 0xA5), requested in the cycle right after done.
- R4: A LINK_TOKEN reply to a token exchange raises `link_up` in the cycle after done, and the following exchanges carry NULL_BYTE.
- R5: During token exchanges, a reply of 0xFF returns the block to polling at once. Any other reply that is not the token resends the token. After TOKEN_TRIES replies without an echo, the block returns to polling with no link-lost pulse.
- R6: While the link settles, a NULL_BYTE reply sets `settled`. A LINK_TOKEN reply leaves the block sending filler. Any other reply except 0xFF sets `settled` and pulses `hdr_strobe` for one cycle, with that byte on `hdr_byte`.
- R7: A 0xFF reply while the link settles pulses `link_lost` for one cycle and clears `link_up`. The block then returns to polling.
- R8: While settled, `xfer_req` stays low and `settled` holds until `recheck` is seen. A recheck sends LINK_TOKEN. A token reply within TOKEN_TRIES exchanges restores `settled`, and `link_up` stays high throughout.
- R9: A 0xFF reply during a re-check, or TOKEN_TRIES replies without an echo, pulses `link_lost` for exactly one cycle, clears `link_up` and restarts polling with the full POLL_GAP wait.
- R10: `recheck` has no effect unless `settled` is high.
- R11: `xfer_tx` holds steady while a request waits for done, and a `xfer_done` that arrives while `xfer_req` is low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| recheck | input | 1 | Request to re-verify the link after a packet |
| xfer_req | output | 1 | Exchange request, held until done |
| xfer_tx | output | 8 | Byte to transmit in the requested exchange |
| xfer_done | input | 1 | One-cycle strobe that ends an exchange |
| xfer_rx | input | 8 | Received byte, valid with done |
| link_up | output | 1 | Token echo seen and link not yet lost |
| link_lost | output | 1 | One-cycle pulse when a live link fails |
| settled | output | 1 | Link up and port idle, ready for data |
| hdr_strobe | output | 1 | One-cycle pulse when a packet header ends the settle phase |
| hdr_byte | output | 8 | Header byte captured with hdr_strobe |

## Verification
A wrong internal phase shows up at the latest on the next exchange request: the transmit byte is the token where filler was due, or the reverse. A phase error can also show as a request gap that is not exactly POLL_GAP cycles, or as a request appearing while `settled` is high. Flag errors show one cycle after the done strobe that should have changed them. A wrong retry count stays hidden until the last attempt, where the block either returns to polling or gives up one exchange early or late.

// File: rtl/spi_link_guard.sv
module spi_link_guard #(
  parameter int          POLL_GAP    = 16,
  parameter int          TOKEN_TRIES = 4,
  parameter logic [7:0]  LINK_TOKEN  = 8'hA5,
  parameter logic [7:0]  NULL_BYTE   = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       recheck,
  output logic       xfer_req,
  output logic [7:0] xfer_tx,
  input  logic       xfer_done,
  input  logic [7:0] xfer_rx,
  output logic       link_up,
  output logic       link_lost,
  output logic       settled,
  output logic       hdr_strobe,
  output logic [7:0] hdr_byte
);

  localparam logic [7:0] ABSENT = 8'hFF;
  localparam int CW = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;
  localparam int TW = (TOKEN_TRIES > 1) ? $clog2(TOKEN_TRIES) : 1;
  localparam logic [CW-1:0] GAP_LAST = CW'(POLL_GAP - 1);
  localparam logic [TW-1:0] TRY_LAST = TW'(TOKEN_TRIES - 1);

  typedef enum logic [2:0] {
    S_WAIT, S_POLL, S_TOKEN, S_SETTLE, S_READY, S_CHECK
  } phase_t;

  phase_t        phase;
  logic [CW-1:0] gap_cnt;
  logic [TW-1:0] misses;

  wire rx_absent = xfer_rx == ABSENT;
  wire rx_token  = xfer_rx == LINK_TOKEN;
  wire rx_null   = xfer_rx == NULL_BYTE;

  assign xfer_req = phase inside {S_POLL, S_TOKEN, S_SETTLE, S_CHECK};
  assign xfer_tx  = (phase == S_TOKEN || phase == S_CHECK) ? LINK_TOKEN : NULL_BYTE;
  assign link_up  = phase inside {S_SETTLE, S_READY, S_CHECK};
  assign settled  = phase == S_READY;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= S_WAIT;
      gap_cnt    <= '0;
      misses     <= '0;
      link_lost  <= 1'b0;
      hdr_strobe <= 1'b0;
      hdr_byte   <= '0;
    end else begin
      link_lost  <= 1'b0;
      hdr_strobe <= 1'b0;
      case (phase)
        S_WAIT: begin
          if (gap_cnt == GAP_LAST) begin
            gap_cnt <= '0;
            phase   <= S_POLL;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        S_POLL: if (xfer_done) begin
          if (rx_absent) phase <= S_WAIT;
          else begin
            phase  <= S_TOKEN;
            misses <= '0;
          end
        end
        S_TOKEN: if (xfer_done) begin
          if (rx_token)                phase <= S_SETTLE;
          else if (rx_absent)          phase <= S_WAIT;
          else if (misses == TRY_LAST) phase <= S_WAIT;
          else                         misses <= misses + 1'b1;
        end
        S_SETTLE: if (xfer_done) begin
          if (rx_absent) begin
            link_lost <= 1'b1;
            phase     <= S_WAIT;
          end else if (rx_null) begin
            phase <= S_READY;
          end else if (!rx_token) begin
            hdr_strobe <= 1'b1;
            hdr_byte   <= xfer_rx;
            phase      <= S_READY;
          end
        end
        S_READY: if (recheck) begin
          phase  <= S_CHECK;
          misses <= '0;
        end
        S_CHECK: if (xfer_done) begin
          if (rx_token) phase <= S_READY;
          else if (rx_absent || misses == TRY_LAST) begin
            link_lost <= 1'b1;
            phase     <= S_WAIT;
          end else begin
            misses <= misses + 1'b1;
          end
        end
        default: phase <= S_WAIT;
      endcase
    end
  end

endmodule

// File: rtl/spi_link_guard_chk.sv
module spi_link_guard_chk #(
  parameter logic [7:0] LINK_TOKEN = 8'hA5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       recheck,
  input logic       xfer_req,
  input logic [7:0] xfer_tx,
  input logic       xfer_done,
  input logic [7:0] xfer_rx,
  input logic       link_up,
  input logic       link_lost,
  input logic       settled,
  input logic       hdr_strobe,
  input logic [7:0] hdr_byte
);

  // R11
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_done |=> xfer_req && $stable(xfer_tx));

  // R4
  up_on_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up) |-> $past(xfer_done) && $past(xfer_rx) == LINK_TOKEN);

  // R9
  lost_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_lost |=> !link_lost);

  // R7
  lost_drops_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_lost |-> !link_up && !xfer_req);

  // R8
  settled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    settled && !recheck |=> settled && !xfer_req);

  // R6
  hdr_in_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_strobe |-> settled && hdr_byte != 8'hFF && hdr_byte != LINK_TOKEN);

  // R10
  recheck_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up && !xfer_req |=> xfer_tx != LINK_TOKEN);

endmodule

bind spi_link_guard spi_link_guard_chk #(.LINK_TOKEN(LINK_TOKEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .recheck(recheck), .xfer_req(xfer_req),
  .xfer_tx(xfer_tx), .xfer_done(xfer_done), .xfer_rx(xfer_rx),
  .link_up(link_up), .link_lost(link_lost), .settled(settled),
  .hdr_strobe(hdr_strobe), .hdr_byte(hdr_byte)
);

// File: tb/spi_link_guard_bench.sv
module spi_link_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int GAP   = 16;
  localparam int TRIES = 4;
  localparam logic [7:0] TOK = 8'hA5;
  localparam logic [7:0] NUL = 8'h00;
  localparam int P_POLL = 0, P_TOK = 1, P_SET = 2, P_RDY = 3, P_CHK = 4;

  logic clk = 0, rst_n = 0, recheck = 0, xfer_done = 0;
  logic [7:0] xfer_rx = 8'h00;
  logic xfer_req, link_up, link_lost, settled, hdr_strobe;
  logic [7:0] xfer_tx, hdr_byte;

  int checks = 0, errors = 0;
  int mph = P_POLL, mfails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_link_guard #(.POLL_GAP(GAP), .TOKEN_TRIES(TRIES), .LINK_TOKEN(TOK), .NULL_BYTE(NUL))
  u_spi_link_guard (
    .clk(clk), .rst_n(rst_n), .recheck(recheck), .xfer_req(xfer_req),
    .xfer_tx(xfer_tx), .xfer_done(xfer_done), .xfer_rx(xfer_rx),
    .link_up(link_up), .link_lost(link_lost), .settled(settled),
    .hdr_strobe(hdr_strobe), .hdr_byte(hdr_byte)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int next_phase(input int ph, input int fails, input logic [7:0] r);
    case (ph)
      P_POLL: return (r == 8'hFF) ? P_POLL : P_TOK;
      P_TOK:  return (r == TOK) ? P_SET : (r == 8'hFF || fails == TRIES-1) ? P_POLL : P_TOK;
      P_SET:  return (r == 8'hFF) ? P_POLL : (r == TOK) ? P_SET : P_RDY;
      P_CHK:  return (r == TOK) ? P_RDY : (r == 8'hFF || fails == TRIES-1) ? P_POLL : P_CHK;
      default: return ph;
    endcase
  endfunction

  function automatic bit lost_expected(input int ph, input int fails, input logic [7:0] r);
    if (ph == P_SET) return r == 8'hFF;
    if (ph == P_CHK) return r != TOK && (r == 8'hFF || fails == TRIES-1);
    return 1'b0;
  endfunction

  function automatic logic [7:0] make_reply(input int sel, input logic [7:0] raw);
    if (sel < 3) return 8'hFF;
    if (sel < 5) return TOK;
    if (sel == 5) return NUL;
    if (raw == 8'hFF || raw == TOK || raw == NUL) return 8'h3C;
    return raw;
  endfunction

  task automatic step(input logic [7:0] reply, input bit poke);
    int low = 0;
    int lat = $urandom % 3;
    int nph;
    bit lst, hdr;
    logic [7:0] tx0;
    while (!xfer_req) begin
      recheck = poke && low == 0;
      low++;
      @(negedge clk);
    end
    recheck = 0;
    check((mph == P_POLL) ? "R2 gap" : "R3 back-to-back", low, (mph == P_POLL) ? GAP : 0);
    if (mph == P_TOK) check("R3/R5 token tx", xfer_tx, TOK);
    else if (mph == P_CHK) check("R8 recheck tx", xfer_tx, TOK);
    else if (mph == P_SET) check("R4 filler tx", xfer_tx, NUL);
    else check(poke ? "R10 filler tx" : "R2 filler tx", xfer_tx, NUL);
    tx0 = xfer_tx;
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      check("R11 tx hold", {xfer_req, xfer_tx}, {1'b1, tx0});
    end
    xfer_done = 1; xfer_rx = reply;
    @(negedge clk);
    xfer_done = 0; xfer_rx = 8'($urandom);
    nph = next_phase(mph, mfails, reply);
    lst = lost_expected(mph, mfails, reply);
    hdr = (mph == P_SET) && reply != 8'hFF && reply != TOK && reply != NUL;
    if ((mph == P_TOK || mph == P_CHK) && nph == mph) mfails++;
    if (nph == P_TOK && mph == P_POLL) mfails = 0;
    check("R4/R7 link_up", link_up, nph == P_SET || nph == P_RDY || nph == P_CHK);
    check(mph == P_CHK ? "R9 link_lost" : "R7 link_lost", link_lost, lst);
    check("R6 settled", settled, nph == P_RDY);
    check("R6 hdr_strobe", hdr_strobe, hdr);
    if (hdr) check("R6 hdr_byte", hdr_byte, reply);
    mph = nph;
  endtask

  task automatic do_recheck();
    recheck = 1;
    @(negedge clk);
    recheck = 0;
    mph = P_CHK; mfails = 0;
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1 req in reset", xfer_req, 0);
    check("R1 link_up in reset", link_up, 0);
    rst_n = 1;
    check("R1 flags", {link_lost, settled, hdr_strobe}, 0);
    step(8'hFF, 0); step(8'hFF, 0);                 // R2
    step(8'h3C, 0);                                 // R3
    step(8'h11, 0); step(TOK, 0);                   // R5 miss, R4 echo
    step(TOK, 0); step(NUL, 0);                     // R6
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R8 idle settled", {settled, xfer_req}, 2'b10);
    end
    xfer_done = 1; xfer_rx = 8'hFF;                 // R11 stray done
    @(negedge clk); xfer_done = 0;
    check("R11 stray done", {settled, link_lost, link_up}, 3'b101);
    do_recheck(); step(8'h22, 0); step(TOK, 0);     // R8
    do_recheck(); step(8'hFF, 0);                   // R9
    step(8'h10, 0);
    for (int i = 0; i < TRIES; i++) step(8'h33, 0); // R5 give up
    step(8'hFF, 0);
    step(8'h01, 0); step(TOK, 0); step(8'h5E, 0);   // R6 header
    do_recheck();
    for (int i = 0; i < TRIES; i++) step(8'h44, 0); // R9 no echo
    step(8'h07, 1);                                 // R10 ignored during wait
    step(TOK, 0); step(8'hFF, 0);                   // R7
    for (int n = 0; n < 500; n++) begin
      if (mph == P_RDY) begin
        repeat ($urandom % 3) @(negedge clk);
        do_recheck();
      end
      step(make_reply($urandom % 8, 8'($urandom)), ($urandom % 4) == 0 && mph == P_POLL);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule